// File: doc/BRIEF.md
# Accumulator Rotate, Subtract and Exchange Unit

This unit executes the accumulator-centred data operations of an 8-bit controller core. The opcode, the current accumulator, the carry flag and an operand byte come in. The operand byte is already fetched from a register, a direct address, an indirect address or an immediate field. The unit covers five kinds of work:
- plain rotates and rotates through carry;
- subtract with borrow;
- the nibble swap;
- whole-byte and low-digit exchanges with memory;
- exclusive-OR, either into the accumulator or into a memory byte.

Each accepted operation produces one registered result set one clock later. The result set holds the new accumulator, a memory write-back byte, and the carry, auxiliary-carry and overflow flags. Each of these has its own write enable, so the surrounding core updates only what the opcode defines.

When an exclusive-OR writes back to a direct address that maps onto an output port, the original byte must come from the port's output latch and not from the pins. The caller marks such a target with `port_target` and supplies the latch contents. The unit then uses those contents as the read-modify-write source.

Top module: `acc_alu_unit`

## Requirements
- R1: Opcode 0x23 rotates the accumulator left one place, bit 7 into bit 0. Opcode 0x03 rotates it right one place, bit 0 into bit 7. Both assert the accumulator enable and no flag enable (0xC5 gives 0x8B left and 0xE2 right).
- R2: Opcode 0x33 rotates carry and accumulator left as one 9-bit ring: bit 7 goes to carry and the old carry goes to bit 0. Opcode 0x13 does the same to the right: bit 0 goes to carry and the old carry goes to bit 7. Only the carry flag enable is asserted.
- R3: Opcodes 0x94 to 0x9F load the accumulator with A minus operand minus carry, modulo 256. They set carry when bit 7 needs a borrow. All three flag enables are asserted.
- R4: For subtraction, auxiliary carry is set when bit 3 needs a borrow. Overflow is set when exactly one of two borrows occurs: the borrow into bit 7 or the borrow out of bit 7. Auxiliary carry is never enabled by any other opcode.
- R5: Opcode 0xC4 exchanges the high and low nibbles of the accumulator, with no flag enable.
- R6: Opcodes 0xD6 and 0xD7 exchange bits 3..0 of the accumulator with bits 3..0 of the operand. Both high nibbles stay unchanged. The accumulator and memory enables are asserted, and no flag enable.
- R7: Opcodes 0xC5 to 0xCF load the accumulator with the operand and write the old accumulator back to memory, both in the same result.
- R8: Opcodes 0x64 to 0x6F load the accumulator with A XOR operand, with no flag enable.
- R9: Opcode 0x62 writes source XOR A to memory, and opcode 0x63 writes source XOR `imm_data` to memory. The accumulator is not enabled. The source is `port_latch` when `port_target` is 1 and `operand` otherwise.
- R10: Any opcode outside the sets above asserts no enable.
- R11: A result appears one clock after `in_valid`. With no valid input, and during reset, `out_valid` and every enable are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Instruction opcode |
| acc_in | input | 8 | Current accumulator |
| cy_in | input | 1 | Current carry flag |
| operand | input | 8 | Fetched source or destination byte |
| imm_data | input | 8 | Immediate mask for the memory XOR form |
| port_latch | input | 8 | Output latch contents of the addressed port |
| port_target | input | 1 | Direct target is an output port |
| out_valid | output | 1 | Result set valid |
| acc_out | output | 8 | New accumulator |
| acc_we | output | 1 | Accumulator write enable |
| mem_out | output | 8 | Memory write-back byte |
| mem_we | output | 1 | Memory write enable |
| cy_out | output | 1 | New carry |
| cy_we | output | 1 | Carry write enable |
| ac_out | output | 1 | New auxiliary carry |
| ac_we | output | 1 | Auxiliary carry write enable |
| ov_out | output | 1 | New overflow |
| ov_we | output | 1 | Overflow write enable |

## Verification
The assertions compare each result against the input sampled one cycle before. They therefore take for granted that `opcode`, `acc_in`, `cy_in` and `operand` are known values whenever `in_valid` is 1, and that `in_valid` is held low throughout reset. The bench drives every input from known constants or from random draws at the falling edge. It keeps `in_valid` at 0 until reset has been released. The random subtraction sweep draws only subtract opcodes, so the flag model applies to every draw.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;
  typedef enum logic [3:0] {
    K_NONE,
    K_ROL,
    K_ROR,
    K_ROLC,
    K_RORC,
    K_SUBB,
    K_SWAP,
    K_XDIG,
    K_XBYTE,
    K_XOR_A,
    K_XOR_MA,
    K_XOR_MI
  } op_kind_e;
endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
  import acc_unit_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind
);
  always_comb begin
    kind = K_NONE;
    casez (opcode)
      8'h23:      kind = K_ROL;
      8'h03:      kind = K_ROR;
      8'h33:      kind = K_ROLC;
      8'h13:      kind = K_RORC;
      8'h94,
      8'h95,
      8'b1001_011?,
      8'b1001_1???: kind = K_SUBB;
      8'hC4:      kind = K_SWAP;
      8'b1101_011?: kind = K_XDIG;
      8'hC5,
      8'b1100_011?,
      8'b1100_1???: kind = K_XBYTE;
      8'h64,
      8'h65,
      8'b0110_011?,
      8'b0110_1???: kind = K_XOR_A;
      8'h62:      kind = K_XOR_MA;
      8'h63:      kind = K_XOR_MI;
      default:    kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/acc_subb.sv
module acc_subb #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bin,
  output logic [W-1:0] diff,
  output logic         bout,
  output logic         half_b,
  output logic         ovf
);
  localparam int HALF = W / 2;

  logic [W:0]      full_d;
  logic [HALF:0]   low_d;
  logic [W-1:0]    top_d;

  always_comb begin
    full_d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
    low_d  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, bin};
    top_d  = {1'b0, a[W-2:0]} - {1'b0, b[W-2:0]} - {{(W-1){1'b0}}, bin};
    diff   = full_d[W-1:0];
    bout   = full_d[W];
    half_b = low_d[HALF];
    ovf    = full_d[W] ^ top_d[W-1];
  end
endmodule

// File: rtl/acc_result_mux.sv
module acc_result_mux
  import acc_unit_pkg::*;
#(
  parameter int W = 8
) (
  input  op_kind_e     kind,
  input  logic [W-1:0] acc,
  input  logic         cy,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] rmw_src,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] sub_diff,
  input  logic         sub_cy,
  input  logic         sub_ac,
  input  logic         sub_ov,
  output logic [W-1:0] acc_nx,
  output logic         acc_en,
  output logic [W-1:0] mem_nx,
  output logic         mem_en,
  output logic         cy_nx,
  output logic         cy_en,
  output logic         ac_nx,
  output logic         ac_en,
  output logic         ov_nx,
  output logic         ov_en
);
  localparam int HALF = W / 2;

  always_comb begin
    acc_nx = acc;
    acc_en = 1'b0;
    mem_nx = opnd;
    mem_en = 1'b0;
    cy_nx  = cy;
    cy_en  = 1'b0;
    ac_nx  = 1'b0;
    ac_en  = 1'b0;
    ov_nx  = 1'b0;
    ov_en  = 1'b0;
    unique case (kind)
      K_ROL: begin
        acc_nx = {acc[W-2:0], acc[W-1]};
        acc_en = 1'b1;
      end
      K_ROR: begin
        acc_nx = {acc[0], acc[W-1:1]};
        acc_en = 1'b1;
      end
      K_ROLC: begin
        acc_nx = {acc[W-2:0], cy};
        cy_nx  = acc[W-1];
        acc_en = 1'b1;
        cy_en  = 1'b1;
      end
      K_RORC: begin
        acc_nx = {cy, acc[W-1:1]};
        cy_nx  = acc[0];
        acc_en = 1'b1;
        cy_en  = 1'b1;
      end
      K_SUBB: begin
        acc_nx = sub_diff;
        cy_nx  = sub_cy;
        ac_nx  = sub_ac;
        ov_nx  = sub_ov;
        acc_en = 1'b1;
        cy_en  = 1'b1;
        ac_en  = 1'b1;
        ov_en  = 1'b1;
      end
      K_SWAP: begin
        acc_nx = {acc[HALF-1:0], acc[W-1:HALF]};
        acc_en = 1'b1;
      end
      K_XDIG: begin
        acc_nx = {acc[W-1:HALF], opnd[HALF-1:0]};
        mem_nx = {opnd[W-1:HALF], acc[HALF-1:0]};
        acc_en = 1'b1;
        mem_en = 1'b1;
      end
      K_XBYTE: begin
        acc_nx = opnd;
        mem_nx = acc;
        acc_en = 1'b1;
        mem_en = 1'b1;
      end
      K_XOR_A: begin
        acc_nx = acc ^ opnd;
        acc_en = 1'b1;
      end
      K_XOR_MA: begin
        mem_nx = rmw_src ^ acc;
        mem_en = 1'b1;
      end
      K_XOR_MI: begin
        mem_nx = rmw_src ^ imm;
        mem_en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_unit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] acc_in,
  input  logic         cy_in,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] imm_data,
  input  logic [W-1:0] port_latch,
  input  logic         port_target,
  output logic         out_valid,
  output logic [W-1:0] acc_out,
  output logic         acc_we,
  output logic [W-1:0] mem_out,
  output logic         mem_we,
  output logic         cy_out,
  output logic         cy_we,
  output logic         ac_out,
  output logic         ac_we,
  output logic         ov_out,
  output logic         ov_we
);
  localparam int HALF = W / 2;

  op_kind_e     kind;
  logic [W-1:0] rmw_src;
  logic [W-1:0] sub_diff;
  logic         sub_cy, sub_ac, sub_ov;
  logic [W-1:0] acc_nx, mem_nx;
  logic         acc_en, mem_en, cy_nx, cy_en, ac_nx, ac_en, ov_nx, ov_en;
  logic [4:0]   en_d;

  acc_op_decode u_dec (
    .opcode (opcode),
    .kind   (kind)
  );

  acc_subb #(.W(W)) u_sub (
    .a      (acc_in),
    .b      (operand),
    .bin    (cy_in),
    .diff   (sub_diff),
    .bout   (sub_cy),
    .half_b (sub_ac),
    .ovf    (sub_ov)
  );

  // Read-modify-write source: a port target reads its output latch.
  always_comb begin
    rmw_src = operand;
    if (port_target && (kind == K_XOR_MA || kind == K_XOR_MI))
      rmw_src = port_latch;
  end

  acc_result_mux #(.W(W)) u_mux (
    .kind     (kind),
    .acc      (acc_in),
    .cy       (cy_in),
    .opnd     (operand),
    .rmw_src  (rmw_src),
    .imm      (imm_data),
    .sub_diff (sub_diff),
    .sub_cy   (sub_cy),
    .sub_ac   (sub_ac),
    .sub_ov   (sub_ov),
    .acc_nx   (acc_nx),
    .acc_en   (acc_en),
    .mem_nx   (mem_nx),
    .mem_en   (mem_en),
    .cy_nx    (cy_nx),
    .cy_en    (cy_en),
    .ac_nx    (ac_nx),
    .ac_en    (ac_en),
    .ov_nx    (ov_nx),
    .ov_en    (ov_en)
  );

  // Enable vector is gated by the input valid.
  always_comb begin
    en_d = in_valid ? {acc_en, mem_en, cy_en, ac_en, ov_en} : 5'b0;
  end

  // Control register: valid and enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      {acc_we, mem_we, cy_we, ac_we, ov_we} <= 5'b0;
    end else begin
      out_valid <= in_valid;
      {acc_we, mem_we, cy_we, ac_we, ov_we} <= en_d;
    end
  end

  // Data register: loaded only on a valid input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      mem_out <= '0;
      cy_out  <= 1'b0;
      ac_out  <= 1'b0;
      ov_out  <= 1'b0;
    end else if (in_valid) begin
      acc_out <= acc_nx;
      mem_out <= mem_nx;
      cy_out  <= cy_nx;
      ac_out  <= ac_nx;
      ov_out  <= ov_nx;
    end
  end

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(acc_we || mem_we || cy_we || ac_we || ov_we));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_ac_only_subtract_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ac_we |-> (cy_we && ov_we && acc_we && !mem_we));

  assert_rotate_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h23) |=>
      (acc_we && !cy_we && acc_out == {$past(acc_in[W-2:0]), $past(acc_in[W-1])}));

  assert_digit_high_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[7:1] == 7'b1101_011) |=>
      (acc_out[W-1:HALF] == $past(acc_in[W-1:HALF]) &&
       mem_out[W-1:HALF] == $past(operand[W-1:HALF])));

  assert_subtract_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[7:3] == 5'b10011) |=>
      ({cy_out, acc_out} == ({1'b0, $past(acc_in)} - {1'b0, $past(operand)}
                             - {{W{1'b0}}, $past(cy_in)})));

  assert_mem_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(cy_we || ac_we || ov_we));
endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;
  typedef struct packed {
    logic [7:0] req;
    logic [7:0] op;
    logic [7:0] a;
    logic       c;
    logic [7:0] opnd;
    logic [7:0] imm;
    logic [7:0] latch;
    logic       ptgt;
    logic [7:0] e_acc;
    logic [7:0] e_mem;
    logic [4:0] e_en;   // {acc, mem, cy, ac, ov}
    logic       e_cy;
    logic       e_ac;
    logic       e_ov;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R1 rotate left / right
    '{8'd1, 8'h23, 8'hC5, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h8B, 8'h00, 5'b10000, 1'b0, 1'b0, 1'b0},
    '{8'd1, 8'h03, 8'hC5, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'hE2, 8'h00, 5'b10000, 1'b0, 1'b0, 1'b0},
    // R2 carry rotates
    '{8'd2, 8'h33, 8'hC5, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h8A, 8'h00, 5'b10100, 1'b1, 1'b0, 1'b0},
    '{8'd2, 8'h13, 8'hC5, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h62, 8'h00, 5'b10100, 1'b1, 1'b0, 1'b0},
    '{8'd2, 8'h33, 8'h01, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 8'h03, 8'h00, 5'b10100, 1'b0, 1'b0, 1'b0},
    // R3 / R4 subtract
    '{8'd3, 8'h9A, 8'hC9, 1'b1, 8'h54, 8'h00, 8'h00, 1'b0, 8'h74, 8'h00, 5'b10111, 1'b0, 1'b0, 1'b1},
    '{8'd4, 8'h94, 8'h00, 1'b0, 8'h01, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h00, 5'b10111, 1'b1, 1'b1, 1'b0},
    '{8'd4, 8'h95, 8'h80, 1'b0, 8'h01, 8'h00, 8'h00, 1'b0, 8'h7F, 8'h00, 5'b10111, 1'b0, 1'b1, 1'b1},
    // R5 swap
    '{8'd5, 8'hC4, 8'hC5, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h5C, 8'h00, 5'b10000, 1'b0, 1'b0, 1'b0},
    // R6 digit exchange
    '{8'd6, 8'hD6, 8'h36, 1'b0, 8'h75, 8'h00, 8'h00, 1'b0, 8'h35, 8'h76, 5'b11000, 1'b0, 1'b0, 1'b0},
    // R7 byte exchange
    '{8'd7, 8'hC6, 8'h3F, 1'b0, 8'h75, 8'h00, 8'h00, 1'b0, 8'h75, 8'h3F, 5'b11000, 1'b0, 1'b0, 1'b0},
    // R8 xor into accumulator
    '{8'd8, 8'h68, 8'hC3, 1'b0, 8'hAA, 8'h00, 8'h00, 1'b0, 8'h69, 8'h00, 5'b10000, 1'b0, 1'b0, 1'b0},
    // R9 xor into memory: latch source, pin source
    '{8'd9, 8'h62, 8'h0F, 1'b0, 8'hF0, 8'h00, 8'h33, 1'b1, 8'h00, 8'h3C, 5'b01000, 1'b0, 1'b0, 1'b0},
    '{8'd9, 8'h63, 8'h00, 1'b0, 8'h55, 8'hFF, 8'h00, 1'b0, 8'h00, 8'hAA, 5'b01000, 1'b0, 1'b0, 1'b0},
    '{8'd9, 8'h63, 8'h00, 1'b0, 8'h55, 8'h0F, 8'hC0, 1'b1, 8'h00, 8'hCF, 5'b01000, 1'b0, 1'b0, 1'b0},
    // R10 unsupported opcode
    '{8'd10, 8'h00, 8'h12, 1'b1, 8'h34, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 5'b00000, 1'b0, 1'b0, 1'b0}
  };

  logic       clk, rst_n, in_valid, cy_in, port_target;
  logic [7:0] opcode, acc_in, operand, imm_data, port_latch;
  logic       out_valid, acc_we, mem_we, cy_out, cy_we, ac_out, ac_we, ov_out, ov_we;
  logic [7:0] acc_out, mem_out;
  int         n_run, n_fail;
  bit         done;

  acc_alu_unit u_acc_alu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .acc_in(acc_in), .cy_in(cy_in), .operand(operand), .imm_data(imm_data),
    .port_latch(port_latch), .port_target(port_target),
    .out_valid(out_valid), .acc_out(acc_out), .acc_we(acc_we),
    .mem_out(mem_out), .mem_we(mem_we), .cy_out(cy_out), .cy_we(cy_we),
    .ac_out(ac_out), .ac_we(ac_we), .ov_out(ov_out), .ov_we(ov_we)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] a, input logic c,
                       input logic [7:0] b, input logic [7:0] im,
                       input logic [7:0] lt, input logic pt);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; acc_in = a; cy_in = c; operand = b;
    imm_data = im; port_latch = lt; port_target = pt;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; opcode = 8'h00; acc_in = 8'h00; cy_in = 1'b0;
    operand = 8'h00; imm_data = 8'h00; port_latch = 8'h00; port_target = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(11, "reset valid+enables", {10'd0, out_valid, acc_we, mem_we, cy_we, ac_we, ov_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(11, "idle valid+enables", {10'd0, out_valid, acc_we, mem_we, cy_we, ac_we, ov_we}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].c, VECS[i].opnd, VECS[i].imm,
            VECS[i].latch, VECS[i].ptgt);
      // outputs registered at the posedge between the two negedges
      check(11, "out_valid", {15'd0, out_valid}, 16'd1);
      check(VECS[i].req, "enables", {11'd0, acc_we, mem_we, cy_we, ac_we, ov_we},
            {11'd0, VECS[i].e_en});
      if (VECS[i].e_en[4]) check(VECS[i].req, "acc", {8'd0, acc_out}, {8'd0, VECS[i].e_acc});
      if (VECS[i].e_en[3]) check(VECS[i].req, "mem", {8'd0, mem_out}, {8'd0, VECS[i].e_mem});
      if (VECS[i].e_en[2]) check(VECS[i].req, "cy", {15'd0, cy_out}, {15'd0, VECS[i].e_cy});
      if (VECS[i].e_en[1]) check(VECS[i].req, "ac", {15'd0, ac_out}, {15'd0, VECS[i].e_ac});
      if (VECS[i].e_en[0]) check(VECS[i].req, "ov", {15'd0, ov_out}, {15'd0, VECS[i].e_ov});
    end

    // R11 a cycle with no valid input leaves enables low
    @(negedge clk);
    check(11, "gap valid+enables", {10'd0, out_valid, acc_we, mem_we, cy_we, ac_we, ov_we}, 16'd0);

    // R3 / R4 random subtract against a 9-bit reference
    for (int k = 0; k < 300; k++) begin
      logic [7:0] ra, rb, rop;
      logic       rc, e_cy, e_ac, e_ov, b7;
      logic [8:0] full;
      logic [4:0] low;
      logic [7:0] sev;
      ra = 8'($urandom); rb = 8'($urandom); rc = 1'($urandom);
      rop = 8'h94 + 8'($urandom_range(0, 11));
      full = {1'b0, ra} - {1'b0, rb} - {8'd0, rc};
      low  = {1'b0, ra[3:0]} - {1'b0, rb[3:0]} - {4'd0, rc};
      sev  = {1'b0, ra[6:0]} - {1'b0, rb[6:0]} - {7'd0, rc};
      b7   = sev[7];
      e_cy = full[8]; e_ac = low[4]; e_ov = full[8] ^ b7;
      drive(rop, ra, rc, rb, 8'h00, 8'h00, 1'b0);
      check(3, "subtract acc", {8'd0, acc_out}, {8'd0, full[7:0]});
      check(3, "subtract cy", {15'd0, cy_out}, {15'd0, e_cy});
      check(4, "subtract ac", {15'd0, ac_out}, {15'd0, e_ac});
      check(4, "subtract ov", {15'd0, ov_out}, {15'd0, e_ov});
    end

    // R11 reset in the middle of a result clears everything
    @(negedge clk);
    in_valid = 1'b1; opcode = 8'h9F; acc_in = 8'h10; operand = 8'h01;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(11, "async reset", {10'd0, out_valid, acc_we, mem_we, cy_we, ac_we, ov_we}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule